// File: doc/BRIEF.md
# Device-Side Translation Cache with Fault Sequencer

This block sits on an I/O device and turns the virtual pages that device clients use into physical pages. It keeps a small fully associative cache whose entries are keyed by a 20-bit address-space identifier together with a virtual page number. A lookup that hits is answered on the next cycle. A lookup that misses is handed to a single miss sequencer, which asks the host-side IOMMU for the translation and holds the client until an answer is ready.

If the IOMMU reports the page as absent, the sequencer does not fail the access. It sends a page request for the same identifier and page and waits for the host to resolve it. On success it asks for the translation again, and only that fresh result is cached and returned. The host can also invalidate one page of an address space, or every page of it. The block acknowledges once the matching entries are gone, and it discards any translation already in flight for the invalidated page by asking again.

Top module: `dev_xlat_cache`

## Requirements
- R1: After reset the cache is empty: `lk_ready` is 1, and `rs_valid`, `tq_valid`, `pq_valid` and `iv_ack` are 0.
- R2: An accepted lookup (`lk_valid` and `lk_ready` high at a clock edge) whose identifier and page match a valid entry raises `rs_valid` for one cycle after that edge, with `rs_err`=0 and the cached physical page on `rs_ppn`. No outbound request is made.
- R3: An accepted lookup that misses raises `tq_valid` in the following cycle, carrying the lookup's identifier and page on `tq_tag`/`tq_vpn`. `lk_ready` stays 0 until that miss is finished.
- R4: A translation response with `tr_present`=1 installs the page and raises `rs_valid` with `rs_ppn`=`tr_ppn` in the cycle after the response. A later lookup of the same page hits.
- R5: A translation response with `tr_present`=0 produces no client response. In the next cycle `pq_valid` rises, carrying the same identifier and page.
- R6: A page response with `pr_ok`=1 leads to a new translation request (`tq_valid`=1, same identifier and page) in the next cycle. Only the result of that second request is returned and installed.
- R7: A page response with `pr_ok`=0 ends the access. `rs_valid`=1 and `rs_err`=1 appear in the next cycle, nothing is installed, and a later lookup of that page misses again.
- R8: Entries are keyed by identifier and page together. The same page under another identifier misses and keeps its own translation.
- R9: An invalidation with `iv_all`=0 removes only the entry that matches both `iv_tag` and `iv_vpn`. `iv_ack` is 1 in the cycle after `iv_valid`, and the entry is already gone by then.
- R10: An invalidation with `iv_all`=1 removes every entry whose identifier equals `iv_tag`, whatever its page. Entries of other identifiers are kept.
- R11: An invalidation that matches the page of a translation request still awaiting its response causes that response to be discarded: no client response is given and a new `tq_valid` request is made.
- R12: Replacement is round robin over the entries in install order. With 8 entries, the ninth install evicts the first one.
- R13: While `tq_valid` is high and `tq_ready` is low, the request stays asserted and `tq_tag`/`tq_vpn` do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_valid | input | 1 | Client lookup request |
| lk_ready | output | 1 | Lookup can be accepted this cycle |
| lk_tag | input | 20 | Address-space identifier of the lookup |
| lk_vpn | input | 20 | Virtual page number of the lookup |
| rs_valid | output | 1 | One-cycle client response |
| rs_err | output | 1 | Response reports an unresolved fault |
| rs_ppn | output | 20 | Physical page of the response |
| tq_valid | output | 1 | Translation request to the host |
| tq_ready | input | 1 | Host accepts the translation request |
| tq_tag | output | 20 | Identifier of the translation request |
| tq_vpn | output | 20 | Page of the translation request |
| tr_valid | input | 1 | Translation response |
| tr_present | input | 1 | Page is present in the host tables |
| tr_ppn | input | 20 | Physical page of the translation response |
| pq_valid | output | 1 | Page request to the host |
| pq_ready | input | 1 | Host accepts the page request |
| pq_tag | output | 20 | Identifier of the page request |
| pq_vpn | output | 20 | Page of the page request |
| pr_valid | input | 1 | Page response |
| pr_ok | input | 1 | Page was made resident |
| iv_valid | input | 1 | One-cycle invalidation from the host |
| iv_all | input | 1 | Invalidate every page of `iv_tag` |
| iv_tag | input | 20 | Identifier to invalidate |
| iv_vpn | input | 20 | Page to invalidate when `iv_all`=0 |
| iv_ack | output | 1 | Invalidation complete |

## Verification
The bench walks the full fault path: absent page, page request, successful resolution, then a second translation. A design that installed the first answer, or skipped the re-request, would respond early or with the wrong physical page. It invalidates a page while its translation response is still pending. A design without the discard would return and cache the stale page instead of re-requesting. Failed page resolution must yield an error and leave the cache untouched, so the page misses again. Reusing one page number under two identifiers exposes a cache keyed on the page alone. Filling past capacity shows whether eviction follows install order.

// File: rtl/dxc_pkg.sv
package dxc_pkg;
  localparam int unsigned DXC_ID_W = 20;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_SEND_TQ,
    SQ_WAIT_TR,
    SQ_SEND_PQ,
    SQ_WAIT_PR
  } sq_state_e;
endpackage

// File: rtl/dxc_entry_store.sv
module dxc_entry_store #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned TAG_W   = 20,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned PPN_W   = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             hit,
  output logic [PPN_W-1:0] hit_ppn,
  input  logic             iv_valid,
  input  logic             iv_all,
  input  logic [TAG_W-1:0] iv_tag,
  input  logic [VPN_W-1:0] iv_vpn,
  input  logic             ins_en,
  input  logic [TAG_W-1:0] ins_tag,
  input  logic [VPN_W-1:0] ins_vpn,
  input  logic [PPN_W-1:0] ins_ppn
);
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld_q, vld_d;
  logic [ENTRIES-1:0] lk_match, iv_match, wr_en;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic [IDX_W-1:0]   ptr_q, ptr_d;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    assign lk_match[i] = vld_q[i] && (tag_q[i] == lk_tag) && (vpn_q[i] == lk_vpn);
    assign iv_match[i] = vld_q[i] && (tag_q[i] == iv_tag) && (iv_all || (vpn_q[i] == iv_vpn));
    assign wr_en[i]    = ins_en && (ptr_q == IDX_W'(i));

    always_comb begin
      vld_d[i] = vld_q[i];
      if (iv_valid && iv_match[i]) vld_d[i] = 1'b0;
      if (wr_en[i])                vld_d[i] = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (wr_en[i]) begin
        tag_q[i] <= ins_tag;
        vpn_q[i] <= ins_vpn;
        ppn_q[i] <= ins_ppn;
      end
    end

    // R9: a matching entry does not survive an exact invalidation
    p_inv_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (iv_valid && !iv_all && vld_q[i] && tag_q[i] == iv_tag && vpn_q[i] == iv_vpn && !wr_en[i])
      |=> !vld_q[i]);
    // R10: an identifier-wide invalidation clears every entry of that identifier
    p_inv_all_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (iv_valid && iv_all && vld_q[i] && tag_q[i] == iv_tag && !wr_en[i]) |=> !vld_q[i]);
  end

  always_comb begin
    hit_ppn = '0;
    for (int k = 0; k < ENTRIES; k++) begin
      if (lk_match[k]) hit_ppn = hit_ppn | ppn_q[k];
    end
  end
  assign hit = |lk_match;

  always_comb begin
    ptr_d = ptr_q;
    if (ins_en) ptr_d = (ptr_q == LAST_IDX) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (ins_en) ptr_q <= ptr_d;
    end
  end

  // R8: no two valid entries ever answer the same lookup
  p_single_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));
endmodule

// File: rtl/dxc_miss_seq.sv
module dxc_miss_seq
  import dxc_pkg::*;
#(
  parameter int unsigned TAG_W = 20,
  parameter int unsigned VPN_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [TAG_W-1:0] st_tag,
  input  logic [VPN_W-1:0] st_vpn,
  output logic             busy,
  output logic             tq_valid,
  input  logic             tq_ready,
  input  logic             tr_valid,
  input  logic             tr_present,
  output logic             pq_valid,
  input  logic             pq_ready,
  input  logic             pr_valid,
  input  logic             pr_ok,
  input  logic             iv_valid,
  input  logic             iv_all,
  input  logic [TAG_W-1:0] iv_tag,
  input  logic [VPN_W-1:0] iv_vpn,
  output logic [TAG_W-1:0] req_tag,
  output logic [VPN_W-1:0] req_vpn,
  output logic             ins_en,
  output logic             done_ok,
  output logic             done_err
);
  sq_state_e        st_q, st_d;
  logic [TAG_W-1:0] tag_q;
  logic [VPN_W-1:0] vpn_q;
  logic             drop_q, drop_d;
  logic             iv_hit, stale;

  assign iv_hit = iv_valid && (iv_tag == tag_q) && (iv_all || (iv_vpn == vpn_q));
  assign stale  = drop_q || iv_hit;

  always_comb begin
    st_d     = st_q;
    drop_d   = drop_q;
    ins_en   = 1'b0;
    done_ok  = 1'b0;
    done_err = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        drop_d = 1'b0;
        if (start) st_d = SQ_SEND_TQ;
      end
      SQ_SEND_TQ: if (tq_ready) st_d = SQ_WAIT_TR;
      SQ_WAIT_TR: begin
        if (iv_hit) drop_d = 1'b1;
        if (tr_valid) begin
          drop_d = 1'b0;
          if (!tr_present)  st_d = SQ_SEND_PQ;
          else if (stale)   st_d = SQ_SEND_TQ;
          else begin
            ins_en  = 1'b1;
            done_ok = 1'b1;
            st_d    = SQ_IDLE;
          end
        end
      end
      SQ_SEND_PQ: if (pq_ready) st_d = SQ_WAIT_PR;
      SQ_WAIT_PR: begin
        if (pr_valid) begin
          if (pr_ok) st_d = SQ_SEND_TQ;
          else begin
            done_err = 1'b1;
            st_d     = SQ_IDLE;
          end
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      drop_q <= 1'b0;
      tag_q  <= '0;
      vpn_q  <= '0;
    end else begin
      st_q   <= st_d;
      drop_q <= drop_d;
      if (start && st_q == SQ_IDLE) begin
        tag_q <= st_tag;
        vpn_q <= st_vpn;
      end
    end
  end

  assign busy     = (st_q != SQ_IDLE);
  assign tq_valid = (st_q == SQ_SEND_TQ);
  assign pq_valid = (st_q == SQ_SEND_PQ);
  assign req_tag  = tag_q;
  assign req_vpn  = vpn_q;

  // R3: an accepted miss makes the sequencer busy
  p_busy_after_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R5: a page request only follows an absent-page answer
  p_pq_after_absent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pq_valid) |-> $past(tr_valid && !tr_present));
  // R6: a resolved page is translated again
  p_retry_after_page_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_WAIT_PR && pr_valid && pr_ok) |=> tq_valid);
  // R4: installs come only from a present translation
  p_install_present_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |-> (tr_valid && tr_present));
  // R7: a failed page response installs nothing
  p_err_no_install_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_err |-> !ins_en);
  // R13: a stalled translation request holds its contents
  p_tq_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (tq_valid && !tq_ready) |=> (tq_valid && $stable(req_tag) && $stable(req_vpn)));
  // R11: an invalidated in-flight page is never installed
  p_no_stale_install_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_WAIT_TR && iv_hit && !tr_valid) |=> !ins_en);
endmodule

// File: rtl/dev_xlat_cache.sv
module dev_xlat_cache
  import dxc_pkg::*;
#(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned TAG_W   = DXC_ID_W,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned PPN_W   = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  output logic             lk_ready,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             rs_valid,
  output logic             rs_err,
  output logic [PPN_W-1:0] rs_ppn,
  output logic             tq_valid,
  input  logic             tq_ready,
  output logic [TAG_W-1:0] tq_tag,
  output logic [VPN_W-1:0] tq_vpn,
  input  logic             tr_valid,
  input  logic             tr_present,
  input  logic [PPN_W-1:0] tr_ppn,
  output logic             pq_valid,
  input  logic             pq_ready,
  output logic [TAG_W-1:0] pq_tag,
  output logic [VPN_W-1:0] pq_vpn,
  input  logic             pr_valid,
  input  logic             pr_ok,
  input  logic             iv_valid,
  input  logic             iv_all,
  input  logic [TAG_W-1:0] iv_tag,
  input  logic [VPN_W-1:0] iv_vpn,
  output logic             iv_ack
);
  logic             rst_meta_q, rst_sync_n;
  logic             hit, busy, lk_fire, start;
  logic [PPN_W-1:0] hit_ppn;
  logic [TAG_W-1:0] req_tag;
  logic [VPN_W-1:0] req_vpn;
  logic             ins_en, done_ok, done_err;
  logic             rs_valid_d, rs_err_d;
  logic [PPN_W-1:0] rs_ppn_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  assign lk_ready = !busy && !iv_valid;
  assign lk_fire  = lk_valid && lk_ready;
  assign start    = lk_fire && !hit;

  dxc_entry_store #(
    .ENTRIES (ENTRIES),
    .TAG_W   (TAG_W),
    .VPN_W   (VPN_W),
    .PPN_W   (PPN_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .lk_tag   (lk_tag),
    .lk_vpn   (lk_vpn),
    .hit      (hit),
    .hit_ppn  (hit_ppn),
    .iv_valid (iv_valid),
    .iv_all   (iv_all),
    .iv_tag   (iv_tag),
    .iv_vpn   (iv_vpn),
    .ins_en   (ins_en),
    .ins_tag  (req_tag),
    .ins_vpn  (req_vpn),
    .ins_ppn  (tr_ppn)
  );

  dxc_miss_seq #(
    .TAG_W (TAG_W),
    .VPN_W (VPN_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start      (start),
    .st_tag     (lk_tag),
    .st_vpn     (lk_vpn),
    .busy       (busy),
    .tq_valid   (tq_valid),
    .tq_ready   (tq_ready),
    .tr_valid   (tr_valid),
    .tr_present (tr_present),
    .pq_valid   (pq_valid),
    .pq_ready   (pq_ready),
    .pr_valid   (pr_valid),
    .pr_ok      (pr_ok),
    .iv_valid   (iv_valid),
    .iv_all     (iv_all),
    .iv_tag     (iv_tag),
    .iv_vpn     (iv_vpn),
    .req_tag    (req_tag),
    .req_vpn    (req_vpn),
    .ins_en     (ins_en),
    .done_ok    (done_ok),
    .done_err   (done_err)
  );

  assign tq_tag = req_tag;
  assign tq_vpn = req_vpn;
  assign pq_tag = req_tag;
  assign pq_vpn = req_vpn;

  always_comb begin
    rs_valid_d = 1'b0;
    rs_err_d   = 1'b0;
    rs_ppn_d   = '0;
    if (lk_fire && hit) begin
      rs_valid_d = 1'b1;
      rs_ppn_d   = hit_ppn;
    end else if (done_ok) begin
      rs_valid_d = 1'b1;
      rs_ppn_d   = tr_ppn;
    end else if (done_err) begin
      rs_valid_d = 1'b1;
      rs_err_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rs_valid <= 1'b0;
      rs_err   <= 1'b0;
      rs_ppn   <= '0;
      iv_ack   <= 1'b0;
    end else begin
      rs_valid <= rs_valid_d;
      rs_err   <= rs_err_d;
      rs_ppn   <= rs_ppn_d;
      iv_ack   <= iv_valid;
    end
  end

  // R2: a hit is answered on the next cycle without error
  p_hit_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (lk_valid && lk_ready && hit) |=> (rs_valid && !rs_err));
  // R9: every invalidation is acknowledged on the next cycle
  p_inv_ack_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    iv_valid |=> iv_ack);
  // R3: no lookup is taken while a miss is outstanding
  p_stall_busy_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tq_valid || pq_valid) |-> !lk_ready);
endmodule

// File: tb/dev_xlat_cache_bench.sv
module dev_xlat_cache_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0, tq_ready = 1'b0, tr_valid = 1'b0, tr_present = 1'b0;
  logic        pq_ready = 1'b0, pr_valid = 1'b0, pr_ok = 1'b0, iv_valid = 1'b0, iv_all = 1'b0;
  logic [19:0] lk_tag = '0, lk_vpn = '0, tr_ppn = '0, iv_tag = '0, iv_vpn = '0;
  logic        lk_ready, rs_valid, rs_err, tq_valid, pq_valid, iv_ack;
  logic [19:0] rs_ppn, tq_tag, tq_vpn, pq_tag, pq_vpn;
  int          n_checks = 0;
  int          n_errors = 0;

  always #5 clk = ~clk;

  dev_xlat_cache u_dev_xlat_cache (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_tag(lk_tag), .lk_vpn(lk_vpn),
    .rs_valid(rs_valid), .rs_err(rs_err), .rs_ppn(rs_ppn),
    .tq_valid(tq_valid), .tq_ready(tq_ready), .tq_tag(tq_tag), .tq_vpn(tq_vpn),
    .tr_valid(tr_valid), .tr_present(tr_present), .tr_ppn(tr_ppn),
    .pq_valid(pq_valid), .pq_ready(pq_ready), .pq_tag(pq_tag), .pq_vpn(pq_vpn),
    .pr_valid(pr_valid), .pr_ok(pr_ok),
    .iv_valid(iv_valid), .iv_all(iv_all), .iv_tag(iv_tag), .iv_vpn(iv_vpn), .iv_ack(iv_ack)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) tick();
    rst_n = 1'b1;
    repeat (3) tick();
  endtask

  task automatic hit_expect(input logic [19:0] t, input logic [19:0] v, input logic [19:0] p, input string req);
    lk_tag = t; lk_vpn = v; lk_valid = 1'b1;
    tick();
    lk_valid = 1'b0;
    chk(rs_valid && !rs_err, req, {30'd0, rs_valid, rs_err}, 32'h2);
    chk(rs_ppn == p, req, rs_ppn, p);
    chk(!tq_valid, req, tq_valid, 0);
  endtask

  task automatic start_miss(input logic [19:0] t, input logic [19:0] v, input string req);
    lk_tag = t; lk_vpn = v; lk_valid = 1'b1;
    tick();
    lk_valid = 1'b0;
    chk(tq_valid && !rs_valid, req, {30'd0, tq_valid, rs_valid}, 32'h2);
    chk(tq_tag == t && tq_vpn == v, req, {tq_tag[11:0], tq_vpn}, {t[11:0], v});
    chk(!lk_ready, req, lk_ready, 0);
  endtask

  task automatic accept_tq();
    tq_ready = 1'b1; tick(); tq_ready = 1'b0;
  endtask

  task automatic give_tr(input bit present, input logic [19:0] p);
    tr_valid = 1'b1; tr_present = present; tr_ppn = p;
    tick();
    tr_valid = 1'b0; tr_present = 1'b0;
  endtask

  task automatic accept_pq();
    pq_ready = 1'b1; tick(); pq_ready = 1'b0;
  endtask

  task automatic give_pr(input bit ok);
    pr_valid = 1'b1; pr_ok = ok; tick(); pr_valid = 1'b0; pr_ok = 1'b0;
  endtask

  task automatic invalidate(input logic [19:0] t, input logic [19:0] v, input bit all, input string req);
    iv_valid = 1'b1; iv_tag = t; iv_vpn = v; iv_all = all;
    tick();
    iv_valid = 1'b0; iv_all = 1'b0;
    chk(iv_ack, req, iv_ack, 1);
  endtask

  task automatic fill(input logic [19:0] t, input logic [19:0] v, input logic [19:0] p, input string req);
    start_miss(t, v, req);
    accept_tq();
    give_tr(1'b1, p);
    chk(rs_valid && !rs_err && rs_ppn == p, req, rs_ppn, p);
    chk(lk_ready, req, lk_ready, 1);
  endtask

  task automatic t_reset();
    chk(lk_ready, "R1 ready", lk_ready, 1);
    chk(!rs_valid && !tq_valid && !pq_valid && !iv_ack, "R1 idle outputs",
        {28'd0, rs_valid, tq_valid, pq_valid, iv_ack}, 0);
  endtask

  task automatic t_fill_and_hit();
    fill(20'h5, 20'h100, 20'hAAA, "R4 fill");
    hit_expect(20'h5, 20'h100, 20'hAAA, "R2 hit");
  endtask

  task automatic t_tag_isolation();
    start_miss(20'h6, 20'h100, "R8 other tag misses");
    accept_tq();
    give_tr(1'b1, 20'hBBB);
    chk(rs_ppn == 20'hBBB, "R8 fill", rs_ppn, 20'hBBB);
    hit_expect(20'h5, 20'h100, 20'hAAA, "R8 first tag kept");
    hit_expect(20'h6, 20'h100, 20'hBBB, "R8 second tag");
  endtask

  task automatic t_stall_hold();
    start_miss(20'h8, 20'h0AB, "R13 start");
    for (int i = 0; i < 3; i++) begin
      tick();
      chk(tq_valid && tq_tag == 20'h8 && tq_vpn == 20'h0AB, "R13 held", tq_vpn, 20'h0AB);
    end
    accept_tq();
    give_tr(1'b1, 20'hEEE);
    chk(rs_valid && rs_ppn == 20'hEEE, "R13 completes", rs_ppn, 20'hEEE);
  endtask

  task automatic t_page_path();
    start_miss(20'h7, 20'h200, "R5 start");
    accept_tq();
    give_tr(1'b0, 20'h999);
    chk(!rs_valid, "R5 no response", rs_valid, 0);
    chk(pq_valid && pq_tag == 20'h7 && pq_vpn == 20'h200, "R5 page request", pq_vpn, 20'h200);
    accept_pq();
    chk(!pq_valid && !tq_valid, "R5 waiting", {30'd0, pq_valid, tq_valid}, 0);
    give_pr(1'b1);
    chk(tq_valid && tq_tag == 20'h7 && tq_vpn == 20'h200, "R6 retranslate", tq_vpn, 20'h200);
    chk(!rs_valid, "R6 no early response", rs_valid, 0);
    accept_tq();
    give_tr(1'b1, 20'hCCC);
    chk(rs_valid && !rs_err && rs_ppn == 20'hCCC, "R6 second result", rs_ppn, 20'hCCC);
    hit_expect(20'h7, 20'h200, 20'hCCC, "R6 installed");
  endtask

  task automatic t_page_fail();
    start_miss(20'h7, 20'h300, "R7 start");
    accept_tq();
    give_tr(1'b0, 20'h0);
    accept_pq();
    give_pr(1'b0);
    chk(rs_valid && rs_err, "R7 error response", {30'd0, rs_valid, rs_err}, 3);
    chk(lk_ready, "R7 idle", lk_ready, 1);
    fill(20'h7, 20'h300, 20'hDDD, "R7 misses again");
  endtask

  task automatic t_inv_exact();
    invalidate(20'h5, 20'h100, 1'b0, "R9 ack");
    hit_expect(20'h6, 20'h100, 20'hBBB, "R9 neighbour kept");
    start_miss(20'h5, 20'h100, "R9 removed");
    accept_tq();
    give_tr(1'b1, 20'hAB1);
    chk(rs_ppn == 20'hAB1, "R9 refill", rs_ppn, 20'hAB1);
  endtask

  task automatic t_inv_all();
    invalidate(20'h7, 20'h0, 1'b1, "R10 ack");
    start_miss(20'h7, 20'h300, "R10 page 300 removed");
    accept_tq();
    give_tr(1'b1, 20'hD01);
    start_miss(20'h7, 20'h200, "R10 page 200 removed");
    accept_tq();
    give_tr(1'b1, 20'hC01);
    hit_expect(20'h6, 20'h100, 20'hBBB, "R10 other tag kept");
  endtask

  task automatic t_inv_inflight();
    start_miss(20'h9, 20'h400, "R11 start");
    accept_tq();
    invalidate(20'h9, 20'h400, 1'b0, "R11 ack");
    give_tr(1'b1, 20'h111);
    chk(!rs_valid, "R11 stale dropped", rs_valid, 0);
    chk(tq_valid && tq_vpn == 20'h400, "R11 re-request", tq_valid, 1);
    accept_tq();
    give_tr(1'b1, 20'h222);
    chk(rs_valid && rs_ppn == 20'h222, "R11 fresh result", rs_ppn, 20'h222);
    hit_expect(20'h9, 20'h400, 20'h222, "R11 fresh installed");
  endtask

  task automatic t_round_robin();
    do_reset();
    for (int i = 0; i < 9; i++) fill(20'h1, 20'(i), 20'(16 + i), "R12 fill");
    hit_expect(20'h1, 20'h1, 20'h11, "R12 second kept");
    hit_expect(20'h1, 20'h8, 20'h18, "R12 newest");
    start_miss(20'h1, 20'h0, "R12 oldest evicted");
    accept_tq();
    give_tr(1'b1, 20'h30);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    do_reset();
    t_reset();
    t_fill_and_hit();
    t_tag_isolation();
    t_stall_hold();
    t_page_path();
    t_page_fail();
    t_inv_exact();
    t_inv_all();
    t_inv_inflight();
    t_round_robin();
    repeat (2) tick();
    finish_run();
  end
endmodule